// File: doc/BRIEF.md
# Temperature Sensor Conversion Sequencer

This block decides when an on-chip temperature sensor converts and keeps the latest result. It drives a one-cycle start pulse to an external converter. It waits for that converter's done strobe, then captures the returned 8-bit code into a status register. It also presents that code as a signed Celsius value, which is the code minus a fixed offset of 60.

A single 8-bit control register sets the behaviour. It selects the mode, the conversion interval, a go bit and a sensor power-down bit. In one-shot mode, software starts a conversion by clearing the go bit and then setting it. In continuous mode, an internal prescaler divides the clock into half-second ticks, and a conversion is requested each time the chosen number of ticks has passed.

Only one conversion is outstanding at a time. A request that arrives while the converter is busy is held as a single pending request. That request is issued on the cycle after the converter finishes.

Top module: `tsense_seq`

## Requirements
- R1: After reset, `ctrl_rd` reads 0xA0, `temp_code` is 0x00, `sensor_pdn` is 0 and `conv_start` is 0.
- R2: A control write sets `ctrl_rd` to the written byte from the next clock edge. The fields are: bits 7:6 interval select; bit 5 mode (1 = one-shot, 0 = continuous); bit 4 go; bit 2 sensor power-down. `sensor_pdn` follows bit 2.
- R3: In one-shot mode, a write with bit 5 = 1, bit 4 = 1 and bit 2 = 0, made while the stored go bit is 0, produces exactly one `conv_start` pulse. The pulse is one cycle wide and is high during the second cycle after the write edge.
- R4: A write that sets go while the stored go bit is already 1 starts no conversion.
- R5: In continuous mode with power-down clear, starts repeat every TICK_DIV × N cycles. N is 8, 1, 2 or 4 for interval select 00, 01, 10 or 11. Any control write restarts the interval count.
- R6: `temp_code` changes only on a `conv_done` cycle while a conversion is outstanding. It then takes `conv_code`. A done strobe with no conversion outstanding is ignored.
- R7: `temp_celsius` is the signed 9-bit value `temp_code` − 60. Code 0x00 gives −60 and code 0xFF gives 195.
- R8: While bit 2 is set, no conversion starts. Any pending request is dropped. An outstanding conversion is abandoned and its later done strobe is ignored.
- R9: A request raised while a conversion is outstanding is kept. This includes a request raised in the same cycle as its done. The kept request causes `conv_start` on the cycle after the done edge, and several such requests collapse into one.
- R10: `conv_start` never pulses while a conversion is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| ctrl_rd | output | 8 | Control register readback |
| conv_start | output | 1 | One-cycle conversion start to the converter |
| conv_done | input | 1 | Converter result valid strobe |
| conv_code | input | 8 | Converter raw result |
| sensor_pdn | output | 1 | Sensor power-down to the converter |
| temp_code | output | 8 | Latest captured raw code |
| temp_celsius | output | 9 | Signed Celsius value of `temp_code` |

## Verification
The converter's done strobe and a new conversion request can land on the same clock edge. The request may come from an interval expiry or from a go-bit edge. The bench provokes this in two ways. It sets the converter stub's latency near and past the continuous interval, so expiries fall before, on and after the done edge. It also issues a go edge while a long conversion is outstanding. In each case a behavioural model predicts the cycle of the next start and the captured code, and every clock is compared. A power-down write during an outstanding conversion with a held request is checked the same way, for a dropped request and an ignored late result.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

    localparam int CODE_W = 8;
    localparam int CTRL_W = 8;

    // control register field positions
    localparam int RATE_LSB = 6;
    localparam int MODE_BIT = 5;
    localparam int GO_BIT   = 4;
    localparam int PDN_BIT  = 2;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'hA0;

    // interval length in half-second ticks for each select value
    function automatic int unsigned interval_ticks(input logic [1:0] sel);
        case (sel)
            2'b00:   return 8;
            2'b01:   return 1;
            2'b10:   return 2;
            default: return 4;
        endcase
    endfunction

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CODE_W-1:0] code;
        logic              pend;
        logic              busy;
        logic              start;
    } seq_state_t;

endpackage

// File: rtl/tsense_interval_timer.sv
module tsense_interval_timer #(
    parameter int unsigned TICK_DIV = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       fire
);
    import tsense_pkg::*;

    localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam int IVL_W = 4;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [IVL_W-1:0] ivl;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [IVL_W-1:0] last_ivl;

    always_comb begin
        tmr_d    = tmr_q;
        fire     = 1'b0;
        last_ivl = IVL_W'(interval_ticks(sel) - 1);
        if (!run) begin
            tmr_d = '0;
        end else if (tmr_q.pre == PRE_W'(TICK_DIV - 1)) begin
            tmr_d.pre = '0;
            if (tmr_q.ivl == last_ivl) begin
                tmr_d.ivl = '0;
                fire      = 1'b1;
            end else begin
                tmr_d.ivl = tmr_q.ivl + 1'b1;
            end
        end else begin
            tmr_d.pre = tmr_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/tsense_celsius.sv
module tsense_celsius #(
    parameter int OFFSET = 60
) (
    input  logic [7:0]        code,
    output logic signed [8:0] celsius
);
    localparam logic signed [8:0] OFS = 9'(OFFSET);

    assign celsius = $signed({1'b0, code}) - OFS;

endmodule

// File: rtl/tsense_seq.sv
module tsense_seq #(
    parameter int unsigned TICK_DIV = 50_000_000,
    parameter int          OFFSET   = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        ctrl_rd,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [7:0]        conv_code,
    output logic              sensor_pdn,
    output logic [7:0]        temp_code,
    output logic signed [8:0] temp_celsius
);
    import tsense_pkg::*;

    seq_state_t st_d, st_q;

    logic [CTRL_W-1:0] ctrl_nx;
    logic              pdn_nx;
    logic              tmr_run;
    logic              tmr_fire;
    logic              go_edge;
    logic              issue;

    assign ctrl_nx = cfg_we ? cfg_wdata : st_q.ctrl;
    assign pdn_nx  = ctrl_nx[PDN_BIT];
    assign tmr_run = !cfg_we && !ctrl_nx[MODE_BIT] && !pdn_nx;

    tsense_interval_timer #(
        .TICK_DIV (TICK_DIV)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .sel   (st_q.ctrl[RATE_LSB +: 2]),
        .fire  (tmr_fire)
    );

    always_comb begin
        st_d    = st_q;
        go_edge = cfg_we && cfg_wdata[GO_BIT] && !st_q.ctrl[GO_BIT]
                  && cfg_wdata[MODE_BIT] && !cfg_wdata[PDN_BIT];
        issue   = !st_q.busy && st_q.pend && !pdn_nx;

        st_d.ctrl  = ctrl_nx;
        st_d.start = issue;

        if (st_q.busy) begin
            if (pdn_nx) begin
                st_d.busy = 1'b0;
            end else if (conv_done) begin
                st_d.busy = 1'b0;
                st_d.code = conv_code;
            end
        end

        if (issue) begin
            st_d.busy = 1'b1;
            st_d.pend = 1'b0;
        end
        if (go_edge || tmr_fire) st_d.pend = 1'b1;
        if (pdn_nx)              st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    tsense_celsius #(
        .OFFSET (OFFSET)
    ) u_celsius (
        .code    (st_q.code),
        .celsius (temp_celsius)
    );

    assign ctrl_rd    = st_q.ctrl;
    assign conv_start = st_q.start;
    assign sensor_pdn = st_q.ctrl[PDN_BIT];
    assign temp_code  = st_q.code;

endmodule

// File: rtl/tsense_seq_chk.sv
module tsense_seq_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        ctrl_rd,
    input logic              conv_start,
    input logic              conv_done,
    input logic              sensor_pdn,
    input logic [7:0]        temp_code,
    input logic signed [8:0] temp_celsius
);

    // R2
    ctrl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (ctrl_rd == $past(cfg_wdata)));

    // R3
    start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R8
    no_start_powered_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_pdn |-> !conv_start);

    // R6
    code_holds_without_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(temp_code));

    // R7
    celsius_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        temp_celsius >= -9'sd60);

endmodule

bind tsense_seq tsense_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .ctrl_rd      (ctrl_rd),
    .conv_start   (conv_start),
    .conv_done    (conv_done),
    .sensor_pdn   (sensor_pdn),
    .temp_code    (temp_code),
    .temp_celsius (temp_celsius)
);

// File: tb/tsense_seq_bench.sv
`timescale 1ns/1ps
module tsense_seq_bench;

    localparam int DIV = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_wdata = 8'h00;
    logic [7:0]        ctrl_rd;
    logic              conv_start;
    logic              conv_done = 1'b0;
    logic [7:0]        conv_code = 8'h00;
    logic              sensor_pdn;
    logic [7:0]        temp_code;
    logic signed [8:0] temp_celsius;

    always #5 clk = ~clk;

    tsense_seq #(.TICK_DIV(DIV), .OFFSET(60)) u_tsense_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .ctrl_rd      (ctrl_rd),
        .conv_start   (conv_start),
        .conv_done    (conv_done),
        .conv_code    (conv_code),
        .sensor_pdn   (sensor_pdn),
        .temp_code    (temp_code),
        .temp_celsius (temp_celsius)
    );

    int ncomp = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        ncomp++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // converter stub
    int   stub_lat  = 5;
    logic [7:0] stub_code = 8'h00;
    bit   spur_req  = 0;
    logic [7:0] spur_code = 8'h3C;
    int   cd = 0;

    always @(negedge clk) begin
        #1;
        conv_done = 1'b0;
        if (spur_req) begin
            conv_done = 1'b1;
            conv_code = spur_code;
            spur_req  = 0;
        end
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                conv_done = 1'b1;
                conv_code = stub_code;
            end
        end
        if (conv_start) cd = stub_lat;
    end

    // behavioural reference model
    logic [7:0] m_ctrl = 8'hA0;
    logic [7:0] m_code = 8'h00;
    bit m_pend = 0, m_busy = 0, m_start = 0;
    int m_cyc = 0;

    function automatic int period_of(input logic [1:0] sel);
        case (sel)
            2'b00: return 8 * DIV;
            2'b01: return DIV;
            2'b10: return 2 * DIV;
            default: return 4 * DIV;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 8'hA0; m_code = 8'h00;
            m_pend = 0; m_busy = 0; m_start = 0; m_cyc = 0;
        end else begin
            logic [7:0] nc;
            bit off, edge_go, fire, go_now, was_busy;
            nc       = cfg_we ? cfg_wdata : m_ctrl;
            off      = nc[2];
            edge_go  = cfg_we && cfg_wdata[4] && !m_ctrl[4] && cfg_wdata[5] && !cfg_wdata[2];
            fire     = 0;
            if (cfg_we || nc[5] || off) m_cyc = 0;
            else begin
                m_cyc++;
                if (m_cyc == period_of(nc[7:6])) begin
                    fire  = 1;
                    m_cyc = 0;
                end
            end
            was_busy = m_busy;
            go_now   = !was_busy && m_pend && !off;
            if (was_busy) begin
                if (off) m_busy = 0;
                else if (conv_done) begin
                    m_busy = 0;
                    m_code = conv_code;
                end
            end
            if (go_now) begin m_busy = 1; m_pend = 0; end
            if (edge_go || fire) m_pend = 1;
            if (off) m_pend = 0;
            m_ctrl  = nc;
            m_start = go_now;
        end
    end

    // per-cycle comparison and start bookkeeping
    int cyc = 0, nstart = 0, last_start = -1, gap = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(conv_start == m_start, "R3 R5 R9 R10 conv_start", conv_start, m_start);
            chk(temp_code == m_code, "R6 temp_code", temp_code, m_code);
            chk(int'(temp_celsius) == int'(m_code) - 60, "R7 temp_celsius",
                int'(temp_celsius), int'(m_code) - 60);
            chk(ctrl_rd == m_ctrl, "R2 ctrl_rd", ctrl_rd, m_ctrl);
            chk(sensor_pdn == m_ctrl[2], "R8 sensor_pdn", sensor_pdn, m_ctrl[2]);
            if (conv_start) begin
                nstart++;
                if (last_start >= 0) gap = cyc - last_start;
                last_start = cyc;
            end
        end
    end

    task automatic wr(input logic [7:0] b);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = b;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        summary();
        $finish;
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk(ctrl_rd == 8'hA0, "R1 ctrl reset", ctrl_rd, 8'hA0);
        chk(temp_code == 8'h00, "R1 code reset", temp_code, 0);
        chk(sensor_pdn == 1'b0, "R1 pdn reset", sensor_pdn, 0);
        chk(conv_start == 1'b0, "R1 start reset", conv_start, 0);
        chk(int'(temp_celsius) == -60, "R7 reset celsius", int'(temp_celsius), -60);

        // R3 one-shot start
        stub_lat = 5; stub_code = 8'h55;
        n0 = nstart;
        wr(8'hB0);
        idle(12);
        chk(nstart - n0 == 1, "R3 one start", nstart - n0, 1);
        chk(temp_code == 8'h55, "R6 captured", temp_code, 8'h55);
        chk(int'(temp_celsius) == 25, "R7 celsius", int'(temp_celsius), 25);
        chk(ctrl_rd == 8'hB0, "R2 readback", ctrl_rd, 8'hB0);

        // R4 go already set
        n0 = nstart;
        wr(8'hB0);
        idle(20);
        chk(nstart - n0 == 0, "R4 no restart", nstart - n0, 0);

        // R7 boundaries
        stub_code = 8'hFF;
        wr(8'hA0); wr(8'hB0);
        idle(12);
        chk(int'(temp_celsius) == 195, "R7 top code", int'(temp_celsius), 195);
        stub_code = 8'h00;
        wr(8'hA0); wr(8'hB0);
        idle(12);
        chk(int'(temp_celsius) == -60, "R7 zero code", int'(temp_celsius), -60);

        // R6 done with nothing outstanding
        spur_code = 8'h3C; spur_req = 1;
        idle(4);
        chk(temp_code == 8'h00, "R6 stray done ignored", temp_code, 0);

        // R8 go edge blocked by power-down
        wr(8'hA4);
        n0 = nstart;
        wr(8'hB4);
        idle(20);
        chk(nstart - n0 == 0, "R8 no start when off", nstart - n0, 0);
        chk(sensor_pdn == 1'b1, "R8 pdn out", sensor_pdn, 1);

        // R8 abandon outstanding and drop held request
        wr(8'hA0);
        stub_lat = 30; stub_code = 8'h77;
        wr(8'hB0);
        wr(8'hA0); wr(8'hB0);
        wr(8'hB4);
        n0 = nstart;
        wr(8'hB0);
        idle(60);
        chk(nstart - n0 == 0, "R8 held request dropped", nstart - n0, 0);
        chk(temp_code == 8'h00, "R8 late result ignored", temp_code, 0);

        // R5 continuous intervals
        stub_lat = 2; stub_code = 8'h40;
        wr(8'h40); idle(3 * DIV + 6);
        chk(gap == DIV, "R5 sel 01", gap, DIV);
        wr(8'h80); idle(6 * DIV + 6);
        chk(gap == 2 * DIV, "R5 sel 10", gap, 2 * DIV);
        wr(8'hC0); idle(12 * DIV + 6);
        chk(gap == 4 * DIV, "R5 sel 11", gap, 4 * DIV);
        wr(8'h00); idle(24 * DIV + 6);
        chk(gap == 8 * DIV, "R5 sel 00", gap, 8 * DIV);
        chk(temp_code == 8'h40, "R6 continuous capture", temp_code, 8'h40);

        // R9 R10 requests held while converter busy
        stub_lat = 10; stub_code = 8'h91;
        wr(8'h40); idle(60);
        chk(gap == 12, "R9 start after done", gap, 12);
        chk(gap >= stub_lat + 2, "R10 no overlap", gap, stub_lat + 2);
        stub_lat = 7; idle(60);
        chk(temp_code == 8'h91, "R9 capture", temp_code, 8'h91);

        // R8 power-down stops continuous
        wr(8'h44);
        n0 = nstart;
        idle(40);
        chk(nstart - n0 == 0, "R8 continuous stopped", nstart - n0, 0);

        summary();
        $finish;
    end

endmodule